// File: doc/BRIEF.md
# I2C Target Controller with Clock Stretching

This block is an I2C target (slave) for an open-drain SDA/SCL pair. It runs on a system clock that is much faster than the bus and oversamples both lines. Each line passes through a two-flop synchronizer and a three-sample glitch filter. The block detects START, repeated START and STOP conditions. After each START it compares the first byte against a programmable own address, which can be 7 or 10 bits wide. It can also answer the all-zero general call address, or acknowledge every address when accept-all mode is on.

Data reaches the surrounding logic through a plain register-style interface. A received byte appears on `rx_data` with a full flag, and a read strobe empties the buffer. A transmit byte is taken from `tx_data`. A one-cycle `irq` pulse marks every event that software must service.

SCL is held low whenever the release bit `rel_state` is 0. Software and hardware both act on this bit, and the rules differ with the stretch-enable setting. Hardware clears the bit when a transmission begins, so software has time to load the next byte. With stretching enabled, hardware also clears it after each acknowledged received byte. Software can then both start and end a stretch. With stretching disabled, software can only release the clock.

Top module: `i2c_target_stretch`

## Requirements
- R1: While `cfg_en` is 0 the block never pulls SDA or SCL low (`sda_oe` = `scl_oe` = 0), and addresses are not acknowledged.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Bytes clocked after a STOP and before any START are ignored. A repeated START restarts address matching.
- R3: With `cfg_addr10` = 0, an address byte whose bits [7:1] equal `own_addr[6:0]` is acknowledged (bit 0 is R/W, 1 = read). Any other address is not acknowledged.
- R4: With `cfg_addr10` = 1, a header byte {11110, `own_addr[9:8]`, 0} is acknowledged, and so is a second byte equal to `own_addr[7:0]`, which opens a write. A wrong second byte is not acknowledged.
- R5: After a complete 10-bit match, a repeated START with header {11110, `own_addr[9:8]`, 1} is acknowledged and enters transmit mode. The same header is not acknowledged after a STOP when no full match has happened since.
- R6: With `cfg_gcall_en` = 1, address byte 0x00 is acknowledged and pulses `irq`. With `cfg_gcall_en` = 0 it is not acknowledged, unless it matches the own address.
- R7: With `cfg_accept_all` = 1, every address byte after a START is acknowledged, whatever its value.
- R8: A data byte is shifted in MSB first. When `rx_full` was 0, the byte is acknowledged, stored in `rx_data`, `rx_full` is set and `irq` pulses. When `rx_full` was 1, the byte is not acknowledged and `rx_data` is kept. A `rx_rd` pulse clears `rx_full`.
- R9: `rel_state` resets to 1. Writing 1 sets it. With `cfg_stretch_en` = 1, writing 0 clears it. SCL is held low exactly while `cfg_en` = 1 and `rel_state` = 0.
- R10: With `cfg_stretch_en` = 0, a software write of 0 to the release bit has no effect.
- R11: In both stretch modes, `rel_state` is cleared when a transmission begins, that is, after a read address or an acknowledged transmitted byte. SCL then stays low until software writes 1.
- R12: With `cfg_stretch_en` = 1, `rel_state` is cleared after each acknowledged received data byte. With `cfg_stretch_en` = 0 it stays 1.
- R13: Transmit bytes leave MSB first from `tx_data`. A master ACK (SDA low on the ninth clock) continues with the next byte. A master NACK returns the block to idle with SDA released until the next START.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Module enable |
| cfg_addr10 | input | 1 | 1 = 10-bit own address, 0 = 7-bit |
| cfg_gcall_en | input | 1 | Answer the general call address |
| cfg_accept_all | input | 1 | Acknowledge every address |
| cfg_stretch_en | input | 1 | Software and receive clock stretching |
| own_addr | input | 10 | Own address (7-bit mode uses [6:0]) |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 = pull SCL low |
| sda_oe | output | 1 | 1 = pull SDA low |
| rel_wr | input | 1 | Write strobe for the release bit |
| rel_wdata | input | 1 | Value written to the release bit |
| rel_state | output | 1 | Release bit read-back (0 = SCL held) |
| tx_data | input | 8 | Byte to transmit |
| rx_data | output | 8 | Last byte received |
| rx_full | output | 1 | Receive buffer holds an unread byte |
| rx_rd | input | 1 | Pulse to empty the receive buffer |
| irq | output | 1 | One-cycle event pulse |

## Verification
The bench sends a second data byte while the receive buffer is still full. A design that ignored the buffer state would acknowledge it and overwrite the stored byte. It writes 0 to the release bit with stretching disabled and enabled, and checks the bit after receptions in both modes. A design with the stretch-enable rules swapped would either lock the bus or never stretch. It checks the 10-bit read turnaround both after a full match and after a STOP. A design that kept the header match across the STOP would answer a read it never set up. It also sends a master NACK mid-read, after which a design that kept driving SDA would corrupt the next transfer.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W     = 8;
  localparam int OWN_ADDR_W = 10;
  localparam logic [4:0] HDR10_PREFIX = 5'b11110;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADR1 = 3'd1,
    ST_ADR2 = 3'd2,
    ST_RX   = 3'd3,
    ST_TX   = 3'd4
  } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_filter.sv
module i2c_tgt_filter #(
  parameter int LINES   = 2,
  parameter int SAMPLES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw,
  output logic [LINES-1:0] clean
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [1:0]         sync_q;
    logic [SAMPLES-1:0] hist_q;
    logic               out_q, out_d;

    always_comb begin
      out_d = out_q;
      if (&hist_q)       out_d = 1'b1;
      else if (~|hist_q) out_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync_q <= '1;
        hist_q <= '1;
        out_q  <= 1'b1;
      end else begin
        sync_q <= {sync_q[0], raw[g]};
        hist_q <= {hist_q[SAMPLES-2:0], sync_q[1]};
        out_q  <= out_d;
      end
    end

    assign clean[g] = out_q;
  end
endmodule

// File: rtl/i2c_tgt_release.sv
module i2c_tgt_release (
  input  logic clk,
  input  logic rst_n,
  input  logic stretch_en,
  input  logic wr,
  input  logic wdata,
  input  logic hw_tx_begin,
  input  logic hw_rx_end,
  output logic rel_q
);
  logic rel_d;

  always_comb begin
    rel_d = rel_q;
    if (hw_tx_begin || (stretch_en && hw_rx_end)) rel_d = 1'b0;
    if (wr) begin
      if (wdata)           rel_d = 1'b1;
      else if (stretch_en) rel_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rel_q <= 1'b1;
    else        rel_q <= rel_d;
  end
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic                  scl_f,
  input  logic                  sda_f,
  input  logic                  addr10,
  input  logic                  gcall_en,
  input  logic                  accept_all,
  input  logic [OWN_ADDR_W-1:0] own_addr,
  input  logic [BYTE_W-1:0]     tx_data,
  input  logic                  rx_rd,
  output logic                  sda_low,
  output logic [BYTE_W-1:0]     rx_data,
  output logic                  rx_full,
  output logic                  irq,
  output logic                  tx_begin,
  output logic                  rx_end
);
  tgt_state_e        state_q, state_d, nxt_q, nxt_d;
  logic [3:0]        bitcnt_q, bitcnt_d;
  logic [BYTE_W-1:0] shreg_q, shreg_d, rxd_q, rxd_d;
  logic scl_q, sda_q, sda_low_d, ack_q, ack_d, hdr_ok_q, hdr_ok_d;
  logic mnack_q, mnack_d, rxf_d, irq_d, txb_d, rxe_d;
  logic rise, fall, start_c, stop_c;

  assign rise    = scl_f & ~scl_q;
  assign fall    = ~scl_f & scl_q;
  assign start_c = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_c  = scl_f & scl_q & ~sda_q & sda_f;

  always_comb begin
    state_d = state_q;  nxt_d = nxt_q;  bitcnt_d = bitcnt_q;
    shreg_d = shreg_q;  rxd_d = rxd_q;  sda_low_d = sda_low;
    ack_d = ack_q;  hdr_ok_d = hdr_ok_q;  mnack_d = mnack_q;
    rxf_d = rx_full & ~rx_rd;
    irq_d = 1'b0;  txb_d = 1'b0;  rxe_d = 1'b0;
    if (!en) begin
      state_d = ST_IDLE;  sda_low_d = 1'b0;  bitcnt_d = '0;  hdr_ok_d = 1'b0;
    end else if (stop_c) begin
      state_d = ST_IDLE;  sda_low_d = 1'b0;  hdr_ok_d = 1'b0;
    end else if (start_c) begin
      state_d = ST_ADR1;  sda_low_d = 1'b0;  bitcnt_d = '0;
    end else if (state_q != ST_IDLE) begin
      // transmit data may change only while SCL is low
      if (state_q == ST_TX && !scl_f && bitcnt_q < 4'd8)
        sda_low_d = ~tx_data[3'd7 - bitcnt_q[2:0]];
      if (rise) begin
        if (bitcnt_q < 4'd8) begin
          shreg_d  = {shreg_q[BYTE_W-2:0], sda_f};
          bitcnt_d = bitcnt_q + 4'd1;
        end else if (bitcnt_q == 4'd9) begin
          mnack_d = sda_f;
        end
      end
      if (fall && bitcnt_q == 4'd8) begin
        bitcnt_d = 4'd9;
        ack_d    = 1'b0;
        unique case (state_q)
          ST_ADR1: begin
            if (accept_all) begin
              ack_d = 1'b1;  nxt_d = shreg_q[0] ? ST_TX : ST_RX;
            end else if (gcall_en && shreg_q == '0) begin
              ack_d = 1'b1;  nxt_d = ST_RX;  irq_d = 1'b1;
            end else if (!addr10 && shreg_q[7:1] == own_addr[6:0]) begin
              ack_d = 1'b1;  nxt_d = shreg_q[0] ? ST_TX : ST_RX;
            end else if (addr10 && shreg_q[7:3] == HDR10_PREFIX &&
                         shreg_q[2:1] == own_addr[9:8]) begin
              if (!shreg_q[0]) begin
                ack_d = 1'b1;  nxt_d = ST_ADR2;
              end else if (hdr_ok_q) begin
                ack_d = 1'b1;  nxt_d = ST_TX;
              end
            end
            if (!ack_d) hdr_ok_d = 1'b0;
          end
          ST_ADR2: begin
            ack_d    = (shreg_q == own_addr[7:0]);
            hdr_ok_d = ack_d;
            nxt_d    = ST_RX;
          end
          ST_RX: begin
            nxt_d = ST_RX;
            if (!rx_full) begin
              ack_d = 1'b1;  rxd_d = shreg_q;  rxf_d = 1'b1;  irq_d = 1'b1;
            end
          end
          default: nxt_d = ST_TX;
        endcase
        sda_low_d = ack_d && state_q != ST_TX;
      end
      if (fall && bitcnt_q == 4'd9) begin
        bitcnt_d  = '0;
        sda_low_d = 1'b0;
        if (state_q == ST_TX) begin
          if (!mnack_q) begin
            txb_d = 1'b1;  irq_d = 1'b1;  sda_low_d = ~tx_data[7];
          end else begin
            state_d = ST_IDLE;
          end
        end else if (!ack_q) begin
          state_d = ST_IDLE;
        end else begin
          state_d = nxt_q;
          if (nxt_q == ST_TX) begin
            txb_d = 1'b1;  irq_d = 1'b1;  sda_low_d = ~tx_data[7];
          end else if (state_q == ST_RX) begin
            rxe_d = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;  nxt_q <= ST_IDLE;  bitcnt_q <= '0;
      shreg_q <= '0;  rxd_q <= '0;  scl_q <= 1'b1;  sda_q <= 1'b1;
      sda_low <= 1'b0;  ack_q <= 1'b0;  hdr_ok_q <= 1'b0;  mnack_q <= 1'b1;
      rx_full <= 1'b0;  irq <= 1'b0;  tx_begin <= 1'b0;  rx_end <= 1'b0;
    end else begin
      state_q <= state_d;  nxt_q <= nxt_d;  bitcnt_q <= bitcnt_d;
      shreg_q <= shreg_d;  rxd_q <= rxd_d;  scl_q <= scl_f;  sda_q <= sda_f;
      sda_low <= sda_low_d;  ack_q <= ack_d;  hdr_ok_q <= hdr_ok_d;
      mnack_q <= mnack_d;  rx_full <= rxf_d;  irq <= irq_d;
      tx_begin <= txb_d;  rx_end <= rxe_d;
    end
  end

  assign rx_data = rxd_q;
endmodule

// File: rtl/i2c_target_stretch.sv
module i2c_target_stretch
  import i2c_tgt_pkg::*;
#(
  parameter int FILT_SAMPLES = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_en,
  input  logic                  cfg_addr10,
  input  logic                  cfg_gcall_en,
  input  logic                  cfg_accept_all,
  input  logic                  cfg_stretch_en,
  input  logic [OWN_ADDR_W-1:0] own_addr,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  scl_oe,
  output logic                  sda_oe,
  input  logic                  rel_wr,
  input  logic                  rel_wdata,
  output logic                  rel_state,
  input  logic [BYTE_W-1:0]     tx_data,
  output logic [BYTE_W-1:0]     rx_data,
  output logic                  rx_full,
  input  logic                  rx_rd,
  output logic                  irq
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic [1:0] line_clean;
  logic       sda_low, hw_tx_begin, hw_rx_end;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  i2c_tgt_filter #(.LINES(2), .SAMPLES(FILT_SAMPLES)) u_filt (
    .clk(clk), .rst_n(rst_int_n), .raw({scl_i, sda_i}), .clean(line_clean)
  );

  i2c_tgt_fsm u_fsm (
    .clk(clk), .rst_n(rst_int_n), .en(cfg_en),
    .scl_f(line_clean[1]), .sda_f(line_clean[0]),
    .addr10(cfg_addr10), .gcall_en(cfg_gcall_en), .accept_all(cfg_accept_all),
    .own_addr(own_addr), .tx_data(tx_data), .rx_rd(rx_rd),
    .sda_low(sda_low), .rx_data(rx_data), .rx_full(rx_full), .irq(irq),
    .tx_begin(hw_tx_begin), .rx_end(hw_rx_end)
  );

  i2c_tgt_release u_rel (
    .clk(clk), .rst_n(rst_int_n), .stretch_en(cfg_stretch_en),
    .wr(rel_wr), .wdata(rel_wdata),
    .hw_tx_begin(hw_tx_begin), .hw_rx_end(hw_rx_end), .rel_q(rel_state)
  );

  assign scl_oe = cfg_en & ~rel_state;
  assign sda_oe = cfg_en & sda_low;
endmodule

// File: rtl/i2c_target_stretch_chk.sv
module i2c_target_stretch_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_en,
  input logic cfg_stretch_en,
  input logic rel_wr,
  input logic rel_wdata,
  input logic rel_state,
  input logic sda_oe,
  input logic rx_full,
  input logic irq,
  input logic hw_tx_begin,
  input logic hw_rx_end
);
  AST_DISABLED_NO_SDA: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> !sda_oe); // R1

  AST_SET_WRITE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    rel_wr && rel_wdata |=> rel_state); // R9

  AST_CLEAR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rel_state) |-> $past(hw_tx_begin ||
      (cfg_stretch_en && (hw_rx_end || (rel_wr && !rel_wdata))))); // R10

  AST_RXFULL_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> irq); // R8
endmodule

bind i2c_target_stretch i2c_target_stretch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_stretch_en(cfg_stretch_en),
  .rel_wr(rel_wr), .rel_wdata(rel_wdata), .rel_state(rel_state),
  .sda_oe(sda_oe), .rx_full(rx_full), .irq(irq),
  .hw_tx_begin(hw_tx_begin), .hw_rx_end(hw_rx_end)
);

// File: tb/tb_i2c_target_stretch.sv
module tb_i2c_target_stretch;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 12;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_en = 1'b0, cfg_addr10 = 1'b0, cfg_gcall_en = 1'b0;
  logic cfg_accept_all = 1'b0, cfg_stretch_en = 1'b0;
  logic [9:0] own_addr = 10'h02A;
  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic scl_line, sda_line, scl_oe, sda_oe;
  logic rel_wr = 1'b0, rel_wdata = 1'b0, rel_state;
  logic [7:0] tx_data = 8'h00, rx_data;
  logic rx_full, rx_rd = 1'b0, irq;
  int n_chk = 0, n_bad = 0, irq_cnt = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign scl_line = ~(m_scl_low | scl_oe);
  assign sda_line = ~(m_sda_low | sda_oe);
  always @(posedge clk) if (irq) irq_cnt <= irq_cnt + 1;

  i2c_target_stretch dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_addr10(cfg_addr10),
    .cfg_gcall_en(cfg_gcall_en), .cfg_accept_all(cfg_accept_all),
    .cfg_stretch_en(cfg_stretch_en), .own_addr(own_addr),
    .scl_i(scl_line), .sda_i(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .rel_wr(rel_wr), .rel_wdata(rel_wdata), .rel_state(rel_state),
    .tx_data(tx_data), .rx_data(rx_data), .rx_full(rx_full), .rx_rd(rx_rd),
    .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_ack7(input logic [7:0] a, input logic [6:0] own7,
                                    input logic gc, input logic all);
    return all || (gc && a == 8'h00) || (a[7:1] == own7);
  endfunction

  task automatic wait_q(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sw_rel(input logic v);
    @(negedge clk); rel_wr = 1'b1; rel_wdata = v;
    @(negedge clk); rel_wr = 1'b0;
  endtask

  task automatic drain;
    @(negedge clk); rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
  endtask

  task automatic bit_io(input logic b, output logic r);
    int t;
    m_sda_low = !b;
    wait_q(Q);
    m_scl_low = 1'b0;
    t = 0;
    while (scl_line == 1'b0 && t < 3000) begin @(negedge clk); t++; end
    if (t >= 3000) chk("R11 SCL never released", 32'(scl_line), 32'd1);
    wait_q(Q);
    r = sda_line;
    wait_q(Q);
    m_scl_low = 1'b1;
    wait_q(Q);
  endtask

  task automatic bus_start;
    sw_rel(1'b1);
    m_sda_low = 1'b0; wait_q(Q);
    m_scl_low = 1'b0; wait_q(Q);
    m_sda_low = 1'b1; wait_q(Q);
    m_scl_low = 1'b1; wait_q(Q);
  endtask

  task automatic bus_stop;
    sw_rel(1'b1);
    m_sda_low = 1'b1; wait_q(Q);
    m_scl_low = 1'b0; wait_q(Q);
    m_sda_low = 1'b0; wait_q(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_io(d[i], r);
    bit_io(1'b1, r);
    ack = !r;
    wait_q(6);
  endtask

  task automatic read_byte(input logic [7:0] load, input logic mack, output logic [7:0] d);
    logic r;
    tx_data = load;
    sw_rel(1'b1);
    d = '0;
    for (int i = 0; i < 8; i++) begin bit_io(1'b1, r); d = {d[6:0], r}; end
    bit_io(!mack, r);
    wait_q(6);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] d;
    int ic;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wait_q(5);
    chk("R9 reset release bit", 32'(rel_state), 32'd1);
    chk("R9 reset scl_oe", 32'(scl_oe), 32'd0);
    chk("R8 reset rx_full", 32'(rx_full), 32'd0);

    // R1: disabled block ignores its address and drives nothing
    cfg_stretch_en = 1'b1;
    bus_start(); send_byte(8'h54, ack); bus_stop();
    chk("R1 no ack while disabled", 32'(ack), 32'd0);
    sw_rel(1'b0); wait_q(3);
    chk("R1 scl_oe stays 0 while disabled", 32'(scl_oe), 32'd0);
    sw_rel(1'b1);
    cfg_stretch_en = 1'b0;
    cfg_en = 1'b1; wait_q(4);

    // R3 / R8: write with buffer empty, then buffer full
    bus_start(); send_byte(8'h54, ack);
    chk("R3 own 7-bit address ack", 32'(ack), 32'd1);
    ic = irq_cnt;
    send_byte(8'hA5, ack);
    chk("R8 data ack when empty", 32'(ack), 32'd1);
    chk("R8 rx_data", 32'(rx_data), 32'hA5);
    chk("R8 rx_full set", 32'(rx_full), 32'd1);
    chk("R8 irq pulse", 32'(irq_cnt - ic), 32'd1);
    send_byte(8'h3C, ack);
    chk("R8 nack when full", 32'(ack), 32'd0);
    chk("R8 rx_data kept", 32'(rx_data), 32'hA5);
    bus_stop(); drain();
    chk("R8 rx_rd clears full", 32'(rx_full), 32'd0);

    // R2: bytes without START ignored; repeated START re-matches
    send_byte(8'h54, ack);
    chk("R2 ignored without START", 32'(ack), 32'd0);
    bus_start(); send_byte(8'h56, ack);
    chk("R3 other address nack", 32'(ack), 32'd0);
    bus_start(); send_byte(8'h54, ack);
    chk("R2 repeated START re-match", 32'(ack), 32'd1);
    bus_stop();

    // R10 / R9: software writes of 0
    sw_rel(1'b0); wait_q(3);
    chk("R10 write 0 ignored", 32'(rel_state), 32'd1);
    chk("R10 scl not held", 32'(scl_oe), 32'd0);
    cfg_stretch_en = 1'b1;
    sw_rel(1'b0); wait_q(3);
    chk("R9 write 0 clears", 32'(rel_state), 32'd0);
    chk("R9 scl held low", 32'(scl_line), 32'd0);
    sw_rel(1'b1); wait_q(3);
    chk("R9 write 1 releases", 32'(scl_line), 32'd1);

    // R12: stretch after reception depends on stretch enable
    bus_start(); send_byte(8'h54, ack); send_byte(8'h77, ack);
    chk("R12 rel cleared after rx (stretch on)", 32'(rel_state), 32'd0);
    m_scl_low = 1'b0; wait_q(4);
    chk("R12 scl held after rx", 32'(scl_line), 32'd0);
    m_scl_low = 1'b1;
    bus_stop(); drain();
    cfg_stretch_en = 1'b0;
    bus_start(); send_byte(8'h54, ack); send_byte(8'h78, ack);
    chk("R12 rel kept after rx (stretch off)", 32'(rel_state), 32'd1);
    bus_stop(); drain();

    // R11 / R13: read with stretch disabled
    bus_start(); send_byte(8'h55, ack);
    chk("R3 read address ack", 32'(ack), 32'd1);
    chk("R11 rel cleared at tx begin", 32'(rel_state), 32'd0);
    m_scl_low = 1'b0; wait_q(4);
    chk("R11 scl held before tx load", 32'(scl_line), 32'd0);
    m_scl_low = 1'b1; wait_q(2);
    read_byte(8'hC3, 1'b1, d);
    chk("R13 first tx byte", 32'(d), 32'hC3);
    chk("R11 rel cleared for next byte", 32'(rel_state), 32'd0);
    read_byte(8'h5A, 1'b0, d);
    chk("R13 second tx byte", 32'(d), 32'h5A);
    wait_q(4);
    chk("R13 SDA released after NACK", 32'(sda_oe), 32'd0);
    bus_stop();

    // R4 / R5: 10-bit addressing
    cfg_addr10 = 1'b1; own_addr = 10'h2B5;
    bus_start(); send_byte(8'hF4, ack);
    chk("R4 header ack", 32'(ack), 32'd1);
    send_byte(8'hB4, ack);
    chk("R4 wrong low byte nack", 32'(ack), 32'd0);
    bus_stop();
    bus_start(); send_byte(8'hF4, ack); send_byte(8'hB5, ack);
    chk("R4 low byte ack", 32'(ack), 32'd1);
    send_byte(8'h11, ack);
    chk("R4 10-bit data", 32'(rx_data), 32'h11);
    drain();
    bus_start(); send_byte(8'hF5, ack);
    chk("R5 read header after match", 32'(ack), 32'd1);
    read_byte(8'h96, 1'b0, d);
    chk("R5 10-bit tx byte", 32'(d), 32'h96);
    bus_stop();
    bus_start(); send_byte(8'hF5, ack);
    chk("R5 read header after STOP nack", 32'(ack), 32'd0);
    bus_stop();
    cfg_addr10 = 1'b0; own_addr = 10'h02A;

    // R6 / R7: general call and accept-all
    cfg_gcall_en = 1'b1;
    ic = irq_cnt;
    bus_start(); send_byte(8'h00, ack); bus_stop();
    chk("R6 general call ack", 32'(ack), 32'd1);
    chk("R6 general call irq", 32'(irq_cnt - ic), 32'd1);
    cfg_gcall_en = 1'b0;
    bus_start(); send_byte(8'h00, ack); bus_stop();
    chk("R6 general call nack when off", 32'(ack), 32'd0);
    cfg_accept_all = 1'b1;
    bus_start(); send_byte(8'h9E, ack); bus_stop();
    chk("R7 accept-all ack", 32'(ack), 32'd1);
    cfg_accept_all = 1'b0;

    // random 7-bit writes
    for (int k = 0; k < 20; k++) begin
      logic [6:0] own7;
      logic [7:0] a, dat;
      logic ea;
      own7 = 7'($urandom_range(1, 127));
      own_addr = {3'b000, own7};
      cfg_gcall_en = 1'($urandom_range(0, 1));
      cfg_accept_all = ($urandom_range(0, 3) == 0);
      a = ($urandom_range(0, 1) == 1) ? {own7, 1'b0} : {7'($urandom), 1'b0};
      if ($urandom_range(0, 5) == 0) a = 8'h00;
      dat = 8'($urandom);
      ea = exp_ack7(a, own7, cfg_gcall_en, cfg_accept_all);
      bus_start(); send_byte(a, ack);
      chk("R3 R6 R7 random address ack", 32'(ack), 32'(ea));
      if (ack) begin
        send_byte(dat, ack);
        chk("R8 random data ack", 32'(ack), 32'd1);
        chk("R8 random data value", 32'(rx_data), 32'(dat));
      end
      bus_stop(); drain();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule